// File: doc/BRIEF.md
# One-Wire Bus Master Engine

This block is the master side of a single one-wire bus. A host sets the operation code, the byte count, the size of the final byte and the transmit data, then pulses `op_start`. The engine runs one of four sequences: a bus reset with presence detection, a write, a read, or a combined write/read. Data is serialized least significant bit first, and the final byte may hold fewer than 8 bits. All slot timing comes from a microsecond tick, produced by a parameterized clock divider.

The drive can go to the shared line as an open-drain pull-down request. It can also go to a separate output pin that drives an external transistor, with either polarity. While the engine is running it raises `busy`, and it ignores any new start request until it returns to idle. A watchdog on the sampled line raises `stuck` when the line stays low longer than a reset pulse while the engine is not pulling it. A single-cycle `stuck_evt` pulse is also produced for an interrupt source.

Top module: `owm_engine`

## Requirements
- R1: With `busy` low, a pulse on `op_start` starts the operation selected by `op_code` (0 bus reset, 1 write, 2 read, 3 write/read). `busy` then stays high for exactly T_RST_TOTAL*US_DIV cycles for a reset, and N*T_SLOT*US_DIV cycles for an operation of N bit slots. The engine pulls the bus only while `busy` is high.
- R2: A pulse on `op_start` while `busy` is high is ignored. The running operation keeps its slot count, timing and result.
- R3: A data operation moves N = 8*`op_bytes` + L bits. `op_bytes` code k means k+1 bytes. L is 8 when `last_size` is 0, and equals `last_size` for codes 1 to 7.
- R4: In a write, slot k carries `wdata[k]` (bit 0 first). A 1 pulls the bus for T_W1 microseconds, a 0 pulls it for T_W0 microseconds, and every slot lasts T_SLOT microseconds.
- R5: In a read, every slot pulls for T_W1 microseconds and the line is sampled T_RD_SAMP microseconds into the slot. The level sampled in slot k lands in `rdata[k]`, and `rdata` bits at and above N read as 0. A write operation leaves `rdata` unchanged.
- R6: In a write/read, slot k drives `wdata[k]` as in R4 and also captures the line into `rdata[k]` as in R5.
- R7: A bus reset pulls the bus for T_RST_LOW microseconds, releases it, and samples the line T_PRES microseconds after the release. `no_presence` takes the sampled level: 0 when a device answered, 1 when none did.
- R8: With `two_wire_en` low, the drive appears on `line_pull` and the alternate pin rests at its released level. With `two_wire_en` high, `line_pull` stays 0 and the drive appears on `alt_out`.
- R9: The released level of `alt_out` is the inverse of `alt_pol`. While pulling the bus in two-wire mode, `alt_out` equals `alt_pol`.
- R10: `stuck` rises once the sampled line has been low for more than T_RST_LOW microseconds while the engine is not pulling. It falls within a few cycles of the line going high again. `stuck_evt` is high for exactly one cycle each time `stuck` rises.
- R11: `wdata`, `op_code`, `op_bytes` and `last_size` are captured at the start. Changing them during an operation has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | Start request, one cycle |
| op_code | input | 2 | 0 reset, 1 write, 2 read, 3 write/read |
| op_bytes | input | BW (2) | Byte count minus one |
| last_size | input | 3 | Bits in final byte, 0 means 8 |
| wdata | input | DW (32) | Transmit data, bit 0 sent first |
| two_wire_en | input | 1 | Drive on the alternate pin instead of the shared line |
| alt_pol | input | 1 | Level of the alternate pin that pulls the bus |
| line_in | input | 1 | Level of the shared bus line |
| line_pull | output | 1 | Pull the shared line low (open-drain enable) |
| alt_out | output | 1 | Alternate output pin |
| busy | output | 1 | Operation in progress |
| no_presence | output | 1 | No device answered the last bus reset |
| rdata | output | DW (32) | Received bits, right-aligned |
| stuck | output | 1 | Line held low outside engine activity |
| stuck_evt | output | 1 | One-cycle pulse when `stuck` rises |

## Verification
The stuck condition is the hardest state to reach from the ports. Every pull-down by the engine resets the watchdog, so only a bus held low by something else, for longer than a full reset pulse, can set it. The bench builds the shared line as the AND of the engine's drive, a modelled slave and a separate forced-low term. It holds that forced term while the engine is idle, and checks `stuck` just before and just after the threshold, then the single event pulse. The ignored start is reached by issuing a reset request partway through a long write and confirming that no long pulse appears and the slot count and busy length are unchanged.

// File: rtl/owm_pkg.sv
// Shared types for the one-wire master engine.
// Assumes: operation codes are fixed by the host-side encoding.
package owm_pkg;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_XFER  = 2'd3
    } owm_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RST  = 2'd1,
        ST_BITS = 2'd2
    } owm_state_e;

endpackage

// File: rtl/owm_tick.sv
// Microsecond tick generator: one-cycle pulse every DIV clocks.
// Assumes: clr realigns the phase so that a slot starting on clr sees
// whole microseconds. With DIV of 1 the tick is permanently high.
module owm_tick #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    generate
        if (DIV > 1) begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt;

            // Count clocks within one microsecond, restart on clr.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    cnt <= '0;
                end else if (cnt == CW'(DIV - 1)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = (cnt == CW'(DIV - 1));
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/owm_slot.sv
// Bit-slot and reset-slot timer. It counts microsecond ticks from start and
// produces the pull-down window, the sample strobe and the end-of-slot pulse.
// Assumes: is_rst and bit_val are stable for the whole slot, and
// T_W1 < T_RD_SAMP < T_W0 < T_SLOT.
module owm_slot #(
    parameter int T_W1        = 6,
    parameter int T_W0        = 60,
    parameter int T_RD_SAMP   = 15,
    parameter int T_SLOT      = 70,
    parameter int T_RST_LOW   = 480,
    parameter int T_PRES      = 70,
    parameter int T_RST_TOTAL = 960
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    input  logic is_rst,
    input  logic bit_val,
    output logic drive_low,
    output logic sample,
    output logic done
);
    localparam int TW = $clog2(T_RST_TOTAL + 1);

    logic          active;
    logic [TW-1:0] t_us;
    logic [TW-1:0] low_len;
    logic [TW-1:0] samp_pt;
    logic [TW-1:0] end_pt;

    // Pick the window lengths for the kind of slot in progress.
    always_comb begin
        if (is_rst) begin
            low_len = TW'(T_RST_LOW);
            samp_pt = TW'(T_RST_LOW + T_PRES);
            end_pt  = TW'(T_RST_TOTAL - 1);
        end else begin
            low_len = bit_val ? TW'(T_W1) : TW'(T_W0);
            samp_pt = TW'(T_RD_SAMP);
            end_pt  = TW'(T_SLOT - 1);
        end
    end

    // Elapsed-microsecond counter for the current slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            t_us   <= '0;
        end else if (start) begin
            active <= 1'b1;
            t_us   <= '0;
        end else if (active && tick) begin
            if (t_us == end_pt) begin
                active <= 1'b0;
            end else begin
                t_us <= t_us + 1'b1;
            end
        end
    end

    assign drive_low = active && (t_us < low_len);
    assign sample    = active && tick && (t_us == samp_pt);
    assign done      = active && tick && (t_us == end_pt);

    // A write-1 or read slot must have let go of the bus before it samples.
    AST_W1_FREE_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !is_rst && bit_val) |-> !drive_low); // R5

endmodule

// File: rtl/owm_shift.sv
// Transmit shifter and receive assembler. It latches the data and the length
// at load, presents the current bit, and stores sampled bits at their stream
// index so that a short final byte is right-aligned.
// Assumes: sample and advance arrive only from data slots of this operation.
module owm_shift #(
    parameter int DATA_BYTES = 4,
    parameter int DW         = DATA_BYTES * 8,
    parameter int BW         = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          load_rd,
    input  logic          load_cap,
    input  logic [BW-1:0] op_bytes,
    input  logic [2:0]    last_size,
    input  logic [DW-1:0] wdata,
    input  logic          sample,
    input  logic          advance,
    input  logic          line,
    output logic          bit_out,
    output logic          last_bit,
    output logic [DW-1:0] rdata
);
    localparam int IW = $clog2(DW + 1);

    logic [DW-1:0] shreg;
    logic [DW-1:0] rxreg;
    logic [IW-1:0] idx;
    logic [IW-1:0] total;
    logic [IW-1:0] nbits;
    logic [3:0]    last_len;
    logic          rd_mode;
    logic          cap_mode;
    logic          running;

    // Number of bits in the requested transfer.
    always_comb begin
        last_len = (last_size == 3'd0) ? 4'd8 : {1'b0, last_size};
        nbits    = IW'({op_bytes, 3'b000}) + IW'(last_len);
    end

    // Load, shift and count the transmit stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            idx      <= '0;
            total    <= '0;
            rd_mode  <= 1'b0;
            cap_mode <= 1'b0;
            running  <= 1'b0;
        end else if (load) begin
            shreg    <= wdata;
            idx      <= '0;
            total    <= nbits;
            rd_mode  <= load_rd;
            cap_mode <= load_cap;
            running  <= 1'b1;
        end else if (advance && running) begin
            shreg <= shreg >> 1;
            idx   <= idx + 1'b1;
            if (last_bit) begin
                running <= 1'b0;
            end
        end
    end

    // Clear receive data at a capturing start, then store each sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxreg <= '0;
        end else if (load) begin
            if (load_cap) begin
                rxreg <= '0;
            end
        end else if (sample && running && cap_mode) begin
            for (int i = 0; i < DW; i++) begin
                if (idx == IW'(i)) begin
                    rxreg[i] <= line;
                end
            end
        end
    end

    assign bit_out  = rd_mode ? 1'b1 : shreg[0];
    assign last_bit = (idx == total - 1'b1);
    assign rdata    = rxreg;

    // The slot index never passes the programmed length.
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (idx < total)); // R3

endmodule

// File: rtl/owm_stuck.sv
// Stuck-line watchdog: counts microseconds of low line while the engine is
// not pulling, and flags when the count passes LIMIT.
// Assumes: line is already synchronized to clk.
module owm_stuck #(
    parameter int LIMIT = 480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line,
    input  logic driving,
    output logic stuck,
    output logic stuck_evt
);
    localparam int CW = $clog2(LIMIT + 2);

    logic [CW-1:0] low_cnt;
    logic          stuck_d;

    // Measure the current stretch of unexplained low level.
    always_ff @(posedge clk) begin
        if (!rst_n || driving || line) begin
            low_cnt <= '0;
        end else if (tick && (low_cnt <= CW'(LIMIT))) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // Remember the previous flag so the rise can be reported once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stuck_d <= 1'b0;
        end else begin
            stuck_d <= stuck;
        end
    end

    assign stuck     = (low_cnt > CW'(LIMIT));
    assign stuck_evt = stuck && !stuck_d;

    AST_STUCK_ONLY_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        stuck |-> $past(!line)); // R10
    AST_STUCK_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stuck_evt |=> !stuck_evt); // R10

endmodule

// File: rtl/owm_engine.sv
// One-wire bus master engine. It sequences reset and data operations over
// the slot timer and shifter, routes the pull-down to the shared line or the
// alternate pin, and watches the line for a stuck-low condition.
// Assumes: two_wire_en and alt_pol are static during an operation, and
// line_in is asynchronous (it is synchronized here).
module owm_engine #(
    parameter int US_DIV      = 50,
    parameter int DATA_BYTES  = 4,
    parameter int T_W1        = 6,
    parameter int T_W0        = 60,
    parameter int T_RD_SAMP   = 15,
    parameter int T_SLOT      = 70,
    parameter int T_RST_LOW   = 480,
    parameter int T_PRES      = 70,
    parameter int T_RST_TOTAL = 960,
    localparam int DW         = DATA_BYTES * 8,
    localparam int BW         = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_start,
    input  logic [1:0]    op_code,
    input  logic [BW-1:0] op_bytes,
    input  logic [2:0]    last_size,
    input  logic [DW-1:0] wdata,
    input  logic          two_wire_en,
    input  logic          alt_pol,
    input  logic          line_in,
    output logic          line_pull,
    output logic          alt_out,
    output logic          busy,
    output logic          no_presence,
    output logic [DW-1:0] rdata,
    output logic          stuck,
    output logic          stuck_evt
);
    import owm_pkg::*;

    owm_state_e state;
    owm_op_e    op_req;
    logic       line_m;
    logic       line_s;
    logic       tick;
    logic       accept;
    logic       slot_start;
    logic       slot_drive;
    logic       slot_sample;
    logic       slot_done;
    logic       cur_bit;
    logic       last_bit;

    assign op_req     = owm_op_e'(op_code);
    assign accept     = op_start && (state == ST_IDLE);
    assign slot_start = accept || ((state == ST_BITS) && slot_done && !last_bit);
    assign busy       = (state != ST_IDLE);

    // Two-stage synchronizer for the bus level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_m <= 1'b1;
            line_s <= 1'b1;
        end else begin
            line_m <= line_in;
            line_s <= line_m;
        end
    end

    owm_tick #(.DIV(US_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (slot_start),
        .tick (tick)
    );

    owm_slot #(
        .T_W1       (T_W1),
        .T_W0       (T_W0),
        .T_RD_SAMP  (T_RD_SAMP),
        .T_SLOT     (T_SLOT),
        .T_RST_LOW  (T_RST_LOW),
        .T_PRES     (T_PRES),
        .T_RST_TOTAL(T_RST_TOTAL)
    ) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .start    (slot_start),
        .is_rst   (state == ST_RST),
        .bit_val  (cur_bit),
        .drive_low(slot_drive),
        .sample   (slot_sample),
        .done     (slot_done)
    );

    owm_shift #(
        .DATA_BYTES(DATA_BYTES),
        .DW        (DW),
        .BW        (BW)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept && (op_req != OP_RESET)),
        .load_rd  (op_req == OP_READ),
        .load_cap ((op_req == OP_READ) || (op_req == OP_XFER)),
        .op_bytes (op_bytes),
        .last_size(last_size),
        .wdata    (wdata),
        .sample   (slot_sample && (state == ST_BITS)),
        .advance  (slot_done && (state == ST_BITS)),
        .line     (line_s),
        .bit_out  (cur_bit),
        .last_bit (last_bit),
        .rdata    (rdata)
    );

    owm_stuck #(.LIMIT(T_RST_LOW)) u_stuck (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .line     (line_s),
        .driving  (slot_drive),
        .stuck    (stuck),
        .stuck_evt(stuck_evt)
    );

    // Operation sequencer: idle, reset slot, or a run of data slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (accept) state <= (op_req == OP_RESET) ? ST_RST : ST_BITS;
                ST_RST:  if (slot_done) state <= ST_IDLE;
                ST_BITS: if (slot_done && last_bit) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Presence result taken at the reset-slot sample point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            no_presence <= 1'b0;
        end else if ((state == ST_RST) && slot_sample) begin
            no_presence <= line_s;
        end
    end

    // Registered pin mux: shared open-drain line or alternate pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_pull <= 1'b0;
            alt_out   <= 1'b1;
        end else begin
            line_pull <= !two_wire_en && slot_drive;
            alt_out   <= two_wire_en ? (slot_drive ? alt_pol : !alt_pol) : !alt_pol;
        end
    end

    AST_DRIVE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        slot_drive |-> busy); // R1
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_start && !slot_done) |=> (busy && (state == $past(state)))); // R2
    AST_SHARED_QUIET_TWO_WIRE: assert property (@(posedge clk) disable iff (!rst_n)
        two_wire_en |=> !line_pull); // R8
    AST_ALT_RELEASED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !two_wire_en |=> (alt_out != $past(alt_pol))); // R9

endmodule

// File: tb/owm_engine_tb.sv
// Self-checking bench: sweeps every byte count and final-byte size over a
// modelled bus with a responding slave, then covers reset, pin modes,
// ignored starts and the stuck watchdog.
module owm_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int SLOT_CYC   = 70 * DIV;
    localparam int RST_CYC    = 960 * DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_start = 1'b0;
    logic [1:0]  op_code = 2'd0;
    logic [1:0]  op_bytes = 2'd0;
    logic [2:0]  last_size = 3'd0;
    logic [31:0] wdata = '0;
    logic        two_wire_en = 1'b0;
    logic        alt_pol = 1'b0;
    logic        line_in;
    logic        line_pull, alt_out, busy, no_presence, stuck, stuck_evt;
    logic [31:0] rdata;

    logic        force_low = 1'b0;
    logic        mon_clr = 1'b0;
    logic        pres_en = 1'b0;
    logic [31:0] resp = '1;
    logic        eff_drive;
    logic        drv_prev = 1'b0;
    int          hold = 0, pres_wait = 0, pres_hold = 0;
    int          npulse = 0, plen = 0, busy_cnt = 0, rsp_idx = 0;
    int          pl_bad = 0, alt_bad = 0, evt_cnt = 0;
    int          pulses [0:63];
    int          n_chk = 0, n_fail = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign eff_drive = two_wire_en ? (alt_pol ? alt_out : !alt_out) : line_pull;
    assign line_in   = !(eff_drive || (hold > 0) || (pres_hold > 0) || force_low);

    owm_engine #(.US_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_code(op_code),
        .op_bytes(op_bytes), .last_size(last_size), .wdata(wdata),
        .two_wire_en(two_wire_en), .alt_pol(alt_pol), .line_in(line_in),
        .line_pull(line_pull), .alt_out(alt_out), .busy(busy),
        .no_presence(no_presence), .rdata(rdata), .stuck(stuck),
        .stuck_evt(stuck_evt)
    );

    // Bus monitor and slave model, evaluated away from the active edge.
    always @(negedge clk) begin
        if (mon_clr) begin
            npulse = 0; plen = 0; busy_cnt = 0; rsp_idx = 0;
            pl_bad = 0; alt_bad = 0; evt_cnt = 0;
        end else begin
            if (busy) busy_cnt++;
            if (two_wire_en && line_pull) pl_bad++;
            if (!two_wire_en && (alt_out != !alt_pol)) alt_bad++;
            if (stuck_evt) evt_cnt++;
            if (eff_drive) begin
                if (!drv_prev) begin
                    if (rsp_idx < 32 && !resp[rsp_idx]) hold = 50;
                    rsp_idx++;
                end
                plen++;
            end else if (drv_prev) begin
                if (npulse < 64) pulses[npulse] = plen;
                npulse++;
                if (pres_en && plen > 500) pres_wait = 30;
                plen = 0;
            end
        end
        drv_prev = eff_drive;
        if (hold > 0) hold--;
        if (pres_wait > 0) begin
            pres_wait--;
            if (pres_wait == 0) pres_hold = 200;
        end else if (pres_hold > 0) begin
            pres_hold--;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Run one operation and check busy length, slot pulses and results.
    task automatic run_op(input logic [1:0] code, input int nb, input int ls,
                          input logic [31:0] wd, input logic [31:0] rs,
                          input bit pres, input bit poke);
        int total, bad, exp_len;
        logic [31:0] mask, exp_rd, prev_rd;
        total   = (code == 2'd0) ? 0 : (nb - 1) * 8 + ((ls == 0) ? 8 : ls);
        mask    = (total >= 32) ? 32'hFFFF_FFFF : ((32'd1 << total) - 32'd1);
        prev_rd = rdata;
        @(posedge clk); #1;
        op_code = code; op_bytes = 2'(nb - 1); last_size = 3'(ls);
        wdata = wd; resp = rs; pres_en = pres; op_start = 1'b1; mon_clr = 1'b1;
        @(posedge clk); #1;
        op_start = 1'b0; mon_clr = 1'b0;
        // R11: scramble the captured inputs once the operation has started.
        wdata = ~wd; op_bytes = ~op_bytes; last_size = ~last_size;
        if (poke) begin
            repeat (200) @(posedge clk);
            #1; op_code = 2'd0; op_start = 1'b1;
            @(posedge clk); #1; op_start = 1'b0;
        end
        do @(negedge clk); while (busy);
        repeat (4) @(negedge clk);
        if (code == 2'd0) begin
            chk(busy_cnt == RST_CYC, "R1", "reset busy cycles", busy_cnt, RST_CYC);
            chk(npulse == 1 && pulses[0] == 480 * DIV, "R7", "reset pulse length",
                pulses[0], 480 * DIV);
            chk(no_presence == !pres, "R7", "no_presence", no_presence, !pres);
        end else begin
            chk(busy_cnt == total * SLOT_CYC, poke ? "R2" : "R1", "busy cycles",
                busy_cnt, total * SLOT_CYC);
            chk(npulse == total, "R3", "slot count", npulse, total);
            bad = 0;
            for (int k = 0; k < total && k < 64; k++) begin
                exp_len = ((code == 2'd2) || wd[k]) ? 6 * DIV : 60 * DIV;
                if (pulses[k] != exp_len) bad++;
            end
            chk(bad == 0, (code == 2'd2) ? "R5" : "R4", "slot pulse lengths", bad, 0);
            case (code)
                2'd1:    exp_rd = prev_rd;
                2'd2:    exp_rd = rs & mask;
                default: exp_rd = wd & rs & mask;
            endcase
            chk(rdata == exp_rd, (code == 2'd3) ? "R6" : "R5", "rdata", rdata, exp_rd);
        end
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 R8 R10: state after reset.
        chk(!busy, "R1", "busy after reset", busy, 0);
        chk(!line_pull && alt_out, "R8", "pins after reset", {line_pull, alt_out}, 1);
        chk(!stuck && !stuck_evt, "R10", "stuck after reset", stuck, 0);
        chk(rdata == 0 && !no_presence, "R5", "rdata after reset", rdata, 0);

        run_op(2'd0, 1, 0, '0, '1, 1'b1, 1'b0);
        run_op(2'd0, 1, 0, '0, '1, 1'b0, 1'b0);

        // R3 R6: every byte count and final-byte size with write/read.
        for (int nb = 1; nb <= 4; nb++) begin
            for (int ls = 0; ls < 8; ls++) begin
                run_op(2'd3, nb, ls, 32'h9E37_79B9 ^ (32'(nb) * 32'h0101_0101) ^ 32'(ls << 3),
                       32'hF0E1_D2C3 ^ (32'(ls) * 32'h1111_1111), 1'b0, 1'b0);
            end
        end

        run_op(2'd2, 4, 0, '0, 32'hA5C3_0F96, 1'b0, 1'b0);
        run_op(2'd2, 2, 5, '0, 32'h0000_2D6B, 1'b0, 1'b0);
        run_op(2'd1, 3, 3, 32'h0012_34C5, '1, 1'b0, 1'b0);
        run_op(2'd1, 1, 1, 32'h0000_0000, '1, 1'b0, 1'b0);
        // R2: reset request in the middle of a write is ignored.
        run_op(2'd1, 2, 0, 32'h0000_5AA5, '1, 1'b0, 1'b1);

        // R8 R9: every pin-mode and polarity combination.
        for (int tw = 0; tw < 2; tw++) begin
            for (int ap = 0; ap < 2; ap++) begin
                @(posedge clk); #1;
                two_wire_en = tw[0]; alt_pol = ap[0];
                repeat (3) @(posedge clk);
                run_op(2'd1, 1, 0, 32'h0000_00B4, '1, 1'b0, 1'b0);
                chk(pl_bad == 0, "R8", "line_pull in two-wire mode", pl_bad, 0);
                chk(alt_bad == 0, "R9", "alt_out held in single mode", alt_bad, 0);
                chk(alt_out == !ap[0], "R9", "alt_out released level", alt_out, !ap[0]);
            end
        end
        @(posedge clk); #1;
        two_wire_en = 1'b0; alt_pol = 1'b0;

        // R10: bus held low by something else while idle.
        @(posedge clk); #1 mon_clr = 1'b1;
        @(posedge clk); #1 mon_clr = 1'b0; force_low = 1'b1;
        repeat (900) @(negedge clk);
        chk(!stuck, "R10", "stuck before limit", stuck, 0);
        repeat (100) @(negedge clk);
        chk(stuck, "R10", "stuck after limit", stuck, 1);
        chk(evt_cnt == 1, "R10", "stuck event pulses", evt_cnt, 1);
        chk(!busy, "R10", "busy while stuck", busy, 0);
        @(posedge clk); #1 force_low = 1'b0;
        repeat (5) @(negedge clk);
        chk(!stuck, "R10", "stuck after release", stuck, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule